// File: doc/BRIEF.md
# Debug Memory Access Port Register Frontend

This block sits behind a debug port and turns its register requests into single-word memory-bus transactions. Each request carries a 4-bit port select, a 4-bit bank select, a 2-bit word index, a read/write flag and 32 bits of write data. The frontend answers only when the port select equals its configured port number. It forms an 8-bit internal offset as `{bank, index, 2'b00}` and decodes that offset into these registers:

- a control/status register, with an enable bit and a busy bit;
- a transfer address register;
- a direct data register;
- four windowed data registers.

Any access to a data register launches one 32-bit transaction on a simple master interface. The interface has request, address, write flag, write data, ready and read data. The direct data register targets the full transfer address. The four windowed registers reach the 16-byte block whose base is the upper 28 bits of the transfer address. A read returns its data on the same cycle as the acknowledge.

The debug side of the system drives one request at a time through a valid/ready pair and waits for the response pulse. Register-only accesses are still accepted while a bus transaction is outstanding, so software can poll the busy bit. A new data access stalls until the current transaction ends.

Top module: `dbg_memport_front`

## Requirements
- R1: A request whose port select differs from the configured port number (parameter `PORT_NUM`, default 2) is dropped. It produces no response, changes no register and starts no bus transaction.
- R2: Offset 0x00 (bank 0, index 0) is control/status. Bit 0 is the enable bit, which is read/write. Bit 1 is busy, which is read-only and reads 1 while a bus transaction is outstanding. All other bits read 0 and ignore writes.
- R3: Offset 0x04 (bank 0, index 1) is the 32-bit transfer address register. It reads back the last value written to it.
- R4: An enabled access to offset 0x0C (bank 0, index 3) starts one bus transaction at the full transfer address. A write drives the request write data; a read does not.
- R5: An enabled access to offsets 0x10, 0x14, 0x18 or 0x1C (bank 1, index n) starts one bus transaction at address `{transfer[31:4], n, 2'b00}`.
- R6: All other offsets are unused: offset 0x08 and banks 2 to 15. Reads of them return 0, writes to them have no effect, and no bus transaction starts.
- R7: The bus request and its address, write flag and write data hold steady until ready is high on a clock edge. On the next cycle the response pulses: it carries the bus read data for a read, and 0 for a write. With a bus that waits L cycles, the response comes L+1 cycles after acceptance.
- R8: While a transaction is outstanding, a data-register access is held off (`req_ready` low). A register-only access is still accepted, and a read of control/status in that window returns busy=1.
- R9: With the enable bit clear, a data-register access is answered one cycle after acceptance with the error flag set and read data 0, and the bus stays idle.
- R10: Data-register accesses, direct or windowed, never change the transfer address register.
- R11: After reset, the enable bit and the transfer address are 0, the bus request is low, no response is pending and `req_ready` is high.
- R12: Accesses to control/status, transfer address and unused offsets are answered exactly one cycle after acceptance, with the error flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Debug-side request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 4 | Port select |
| req_bank | input | 4 | Bank select, offset bits [7:4] |
| req_idx | input | 2 | Word index, offset bits [3:2] |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Access refused (enable clear) |
| rsp_rdata | output | 32 | Read data returned with the response |
| bus_req | output | 1 | Bus transaction outstanding |
| bus_addr | output | 32 | Bus byte address |
| bus_we | output | 1 | Bus write flag |
| bus_wdata | output | 32 | Bus write data |
| bus_ready | input | 1 | Bus completes the transaction this edge |
| bus_rdata | input | 32 | Bus read data, valid with ready |

## Verification
A corrupted transfer address or a wrong decoded register kind shows up on `bus_addr` on the first cycle of the next data transaction. It also shows up in the very next read of the transfer register, one cycle after acceptance. A stuck busy state leaves `bus_req` high or keeps `req_ready` low, so the next data access never gets a response. A lost enable bit either sends an error response the cycle after acceptance or lets a transaction start where none is allowed. Either effect is visible at the ports within two cycles of the access.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    localparam int DMP_AW = 32;
    localparam int DMP_DW = 32;
    localparam int DMP_PW = 4;
    localparam int DMP_BW = 4;
    localparam int DMP_IW = 2;
    localparam int DMP_OW = DMP_BW + DMP_IW + 2;

    localparam int CSR_EN_BIT   = 0;
    localparam int CSR_BUSY_BIT = 1;

    localparam logic [DMP_OW-1:0] OFF_CTRL = 8'h00;
    localparam logic [DMP_OW-1:0] OFF_XADR = 8'h04;
    localparam logic [DMP_OW-1:0] OFF_DDAT = 8'h0C;
    localparam logic [DMP_OW-1:0] OFF_WIN0 = 8'h10;
    localparam logic [DMP_OW-1:0] OFF_WIN1 = 8'h14;
    localparam logic [DMP_OW-1:0] OFF_WIN2 = 8'h18;
    localparam logic [DMP_OW-1:0] OFF_WIN3 = 8'h1C;

    typedef enum logic [2:0] {
        RK_CTRL,
        RK_XADR,
        RK_DDAT,
        RK_WIN,
        RK_NONE
    } reg_kind_e;

    typedef struct packed {
        logic              en;
        logic              busy;
        logic [DMP_AW-1:0] xadr;
        logic              rsp_valid;
        logic              rsp_err;
        logic [DMP_DW-1:0] rsp_rdata;
        logic [DMP_AW-1:0] bus_addr;
        logic              bus_we;
        logic [DMP_DW-1:0] bus_wdata;
    } front_state_t;

endpackage

// File: rtl/dmp_decode.sv
module dmp_decode
    import dmp_pkg::*;
(
    input  logic [DMP_BW-1:0] bank,
    input  logic [DMP_IW-1:0] idx,
    output reg_kind_e         kind
);

    logic [DMP_OW-1:0] offset;

    always_comb begin
        offset = {bank, idx, 2'b00};
        unique case (offset)
            OFF_CTRL: kind = RK_CTRL;
            OFF_XADR: kind = RK_XADR;
            OFF_DDAT: kind = RK_DDAT;
            OFF_WIN0,
            OFF_WIN1,
            OFF_WIN2,
            OFF_WIN3: kind = RK_WIN;
            default:  kind = RK_NONE;
        endcase
    end

endmodule

// File: rtl/dmp_addr_form.sv
module dmp_addr_form
    import dmp_pkg::*;
#(
    parameter int AW = DMP_AW
) (
    input  logic [AW-1:0]     xadr,
    input  reg_kind_e         kind,
    input  logic [DMP_IW-1:0] idx,
    output logic [AW-1:0]     addr
);

    localparam int LOW_W = DMP_IW + 2;

    always_comb begin
        if (kind == RK_WIN) begin
            addr = {xadr[AW-1:LOW_W], idx, 2'b00};
        end else begin
            addr = xadr;
        end
    end

endmodule

// File: rtl/dbg_memport_front.sv
module dbg_memport_front
    import dmp_pkg::*;
#(
    parameter logic [DMP_PW-1:0] PORT_NUM = 4'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [DMP_PW-1:0] req_port,
    input  logic [DMP_BW-1:0] req_bank,
    input  logic [DMP_IW-1:0] req_idx,
    input  logic [DMP_DW-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DMP_DW-1:0] rsp_rdata,
    output logic              bus_req,
    output logic [DMP_AW-1:0] bus_addr,
    output logic              bus_we,
    output logic [DMP_DW-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DMP_DW-1:0] bus_rdata
);

    front_state_t state_d, state_q;
    reg_kind_e         kind;
    logic [DMP_AW-1:0] tx_addr;
    logic              port_hit;
    logic              is_data;
    logic              bus_done;
    logic              accept;

    dmp_decode u_decode (
        .bank (req_bank),
        .idx  (req_idx),
        .kind (kind)
    );

    dmp_addr_form #(.AW(DMP_AW)) u_addr_form (
        .xadr (state_q.xadr),
        .kind (kind),
        .idx  (req_idx),
        .addr (tx_addr)
    );

    always_comb begin
        port_hit  = (req_port == PORT_NUM);
        is_data   = (kind == RK_DDAT) || (kind == RK_WIN);
        bus_done  = state_q.busy && bus_ready;
        req_ready = !(state_q.busy && (is_data || bus_ready));
        accept    = req_valid && req_ready && port_hit;

        state_d           = state_q;
        state_d.rsp_valid = 1'b0;
        state_d.rsp_err   = 1'b0;
        state_d.rsp_rdata = '0;

        if (bus_done) begin
            state_d.busy      = 1'b0;
            state_d.rsp_valid = 1'b1;
            state_d.rsp_rdata = state_q.bus_we ? '0 : bus_rdata;
        end

        if (accept) begin
            unique case (kind)
                RK_CTRL: begin
                    state_d.rsp_valid = 1'b1;
                    if (req_write) begin
                        state_d.en = req_wdata[CSR_EN_BIT];
                    end else begin
                        state_d.rsp_rdata[CSR_EN_BIT]   = state_q.en;
                        state_d.rsp_rdata[CSR_BUSY_BIT] = state_q.busy;
                    end
                end
                RK_XADR: begin
                    state_d.rsp_valid = 1'b1;
                    if (req_write) begin
                        state_d.xadr = req_wdata;
                    end else begin
                        state_d.rsp_rdata = state_q.xadr;
                    end
                end
                RK_DDAT, RK_WIN: begin
                    if (!state_q.en) begin
                        state_d.rsp_valid = 1'b1;
                        state_d.rsp_err   = 1'b1;
                    end else begin
                        state_d.busy      = 1'b1;
                        state_d.bus_addr  = tx_addr;
                        state_d.bus_we    = req_write;
                        state_d.bus_wdata = req_write ? req_wdata : '0;
                    end
                end
                default: begin
                    state_d.rsp_valid = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.rsp_valid;
    assign rsp_err   = state_q.rsp_err;
    assign rsp_rdata = state_q.rsp_rdata;
    assign bus_req   = state_q.busy;
    assign bus_addr  = state_q.bus_addr;
    assign bus_we    = state_q.bus_we;
    assign bus_wdata = state_q.bus_wdata;

endmodule

// File: rtl/dbg_memport_front_chk.sv
module dbg_memport_front_chk
    import dmp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ready,
    input logic [DMP_AW-1:0] bus_addr,
    input logic              bus_we,
    input logic [DMP_DW-1:0] bus_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DMP_AW-1:0] xadr_q,
    input logic              en_q
);

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R7

    AST_ACK_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ready |=> rsp_valid && !bus_req); // R7

    AST_WINDOW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> bus_addr[DMP_AW-1:4] == xadr_q[DMP_AW-1:4]); // R5

    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> en_q); // R9

    AST_ERR_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> !bus_req); // R9

endmodule

bind dbg_memport_front dbg_memport_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .xadr_q    (state_q.xadr),
    .en_q      (state_q.en)
);

// File: tb/dbg_memport_front_tb.sv
`timescale 1ns/1ps
module dbg_memport_front_tb;

    localparam logic [3:0]  MYPORT = 4'd2;
    localparam logic [31:0] KEY    = 32'h5A5A_0F0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [3:0]  req_port = '0;
    logic [3:0]  req_bank = '0;
    logic [1:0]  req_idx = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_rdata = '0;

    int total = 0;
    int bad = 0;
    int lat_cfg = 0;
    int wait_cnt = 0;
    int txn = 0;
    logic [31:0] t_addr = '0, t_wd = '0;
    logic        t_we = 1'b0;

    always #2.5 clk = ~clk;

    dbg_memport_front #(.PORT_NUM(MYPORT)) u_dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_port,
        .req_bank, .req_idx, .req_wdata, .rsp_valid, .rsp_err, .rsp_rdata,
        .bus_req, .bus_addr, .bus_we, .bus_wdata, .bus_ready, .bus_rdata
    );

    // Bus slave: ready after lat_cfg waiting cycles, read data = address ^ KEY
    always @(negedge clk) begin
        if (bus_req) begin
            bus_ready = (wait_cnt >= lat_cfg);
            bus_rdata = bus_addr ^ KEY;
            wait_cnt  = wait_cnt + 1;
        end else begin
            bus_ready = 1'b0;
            wait_cnt  = 0;
        end
    end

    always @(posedge clk) begin
        if (rst_n && bus_req && bus_ready) begin
            txn    = txn + 1;
            t_addr = bus_addr;
            t_we   = bus_we;
            t_wd   = bus_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [3:0] port, input logic [3:0] bank, input logic [1:0] idx,
                       input bit wr, input logic [31:0] wd,
                       output bit got, output bit err, output logic [31:0] rd, output int n);
        @(negedge clk);
        req_valid = 1'b1; req_port = port; req_bank = bank; req_idx = idx;
        req_write = wr; req_wdata = wd;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
        got = rsp_valid; err = rsp_err; rd = rsp_rdata;
    endtask

    function automatic logic [31:0] win_addr(input logic [31:0] t, input logic [1:0] i);
        return {t[31:4], i, 2'b00};
    endfunction

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        bit got, err;
        logic [31:0] rd, tv, ea;
        int n, t0;

        repeat (3) @(negedge clk);
        chk("R11 rsp_valid", {31'b0, rsp_valid}, 0);
        chk("R11 bus_req", {31'b0, bus_req}, 0);
        chk("R11 req_ready", {31'b0, req_ready}, 1);
        rst_n = 1'b1;
        acc(MYPORT, 4'd0, 2'd0, 0, 0, got, err, rd, n);
        chk("R11 ctrl after reset", rd, 0);
        acc(MYPORT, 4'd0, 2'd1, 0, 0, got, err, rd, n);
        chk("R11 xadr after reset", rd, 0);

        // R9: enable clear -> refused, bus idle
        t0 = txn;
        acc(MYPORT, 4'd0, 2'd3, 0, 0, got, err, rd, n);
        chk("R9 err direct", {31'b0, err}, 1);
        chk("R9 latency", n, 0);
        chk("R9 rdata", rd, 0);
        acc(MYPORT, 4'd1, 2'd2, 1, 32'hDEAD_BEEF, got, err, rd, n);
        chk("R9 err window", {31'b0, err}, 1);
        chk("R9 no bus", txn, t0);

        // R2: only bit 0 writable
        acc(MYPORT, 4'd0, 2'd0, 1, 32'hFFFF_FFFF, got, err, rd, n);
        chk("R12 ctrl write latency", n, 0);
        acc(MYPORT, 4'd0, 2'd0, 0, 0, got, err, rd, n);
        chk("R2 ctrl en=1", rd, 32'h1);
        acc(MYPORT, 4'd0, 2'd0, 1, 32'hFFFF_FFFE, got, err, rd, n);
        acc(MYPORT, 4'd0, 2'd0, 0, 0, got, err, rd, n);
        chk("R2 ctrl en=0", rd, 32'h0);
        acc(MYPORT, 4'd0, 2'd0, 1, 32'h1, got, err, rd, n);

        // R3: transfer address round trip
        tv = 32'h1234_567B;
        acc(MYPORT, 4'd0, 2'd1, 1, tv, got, err, rd, n);
        acc(MYPORT, 4'd0, 2'd1, 0, 0, got, err, rd, n);
        chk("R3 xadr readback", rd, tv);
        chk("R12 xadr latency", n, 0);
        chk("R12 xadr err", {31'b0, err}, 0);

        // Sweep all offsets, both directions (ctrl/xadr writes skipped)
        for (int b = 0; b < 16; b++) begin
            for (int i = 0; i < 4; i++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] wd;
                    bit data_off;
                    if (w == 1 && b == 0 && (i == 0 || i == 1)) continue;
                    wd = (32'h0101_0101 * (b * 4 + i + 1)) ^ 32'hC3C3_0000;
                    lat_cfg = (b + i + w) % 3;
                    data_off = (b == 0 && i == 3) || (b == 1);
                    ea = (b == 1) ? win_addr(tv, i[1:0]) : tv;
                    t0 = txn;
                    acc(MYPORT, b[3:0], i[1:0], w[0], wd, got, err, rd, n);
                    chk("R12/R7 response seen", {31'b0, got}, 1);
                    chk("R9 err clear when enabled", {31'b0, err}, 0);
                    if (data_off) begin
                        chk((b == 1) ? "R5 one txn" : "R4 one txn", txn, t0 + 1);
                        chk((b == 1) ? "R5 addr" : "R4 addr", t_addr, ea);
                        chk("R4 we", {31'b0, t_we}, w);
                        if (w == 1) chk("R4 wdata", t_wd, wd);
                        chk("R7 rdata", rd, (w == 1) ? 32'h0 : (ea ^ KEY));
                        chk("R7 latency", n, lat_cfg + 1);
                    end else begin
                        chk("R6 no txn", txn, t0);
                        chk("R12 latency", n, 0);
                        if (b == 0 && i == 0)      chk("R2 ctrl read", rd, 32'h1);
                        else if (b == 0 && i == 1) chk("R3 xadr read", rd, tv);
                        else                       chk("R6 reads zero", rd, 0);
                    end
                end
            end
        end
        acc(MYPORT, 4'd0, 2'd1, 0, 0, got, err, rd, n);
        chk("R10 xadr unchanged after data accesses", rd, tv);
        acc(MYPORT, 4'd0, 2'd0, 0, 0, got, err, rd, n);
        chk("R6 ctrl unchanged after unused writes", rd, 32'h1);

        // R1: other ports dropped
        t0 = txn;
        for (int p = 0; p < 16; p++) begin
            if (p == MYPORT) continue;
            acc(p[3:0], 4'd0, 2'd1, 1, 32'hFFFF_0000, got, err, rd, n);
            chk("R1 no response", {31'b0, got}, 0);
            acc(p[3:0], 4'd0, 2'd3, 0, 0, got, err, rd, n);
            chk("R1 no response data", {31'b0, got}, 0);
        end
        chk("R1 no bus", txn, t0);
        acc(MYPORT, 4'd0, 2'd1, 0, 0, got, err, rd, n);
        chk("R1 xadr kept", rd, tv);

        // R8: busy window
        lat_cfg = 10;
        @(negedge clk);
        req_valid = 1'b1; req_port = MYPORT; req_bank = 4'd0; req_idx = 2'd3; req_write = 1'b0;
        @(negedge clk);
        req_bank = 4'd0; req_idx = 2'd0;
        #1;
        chk("R8 ctrl accepted while busy", {31'b0, req_ready}, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 busy response", {31'b0, rsp_valid}, 1);
        chk("R8 busy bit", rsp_rdata, 32'h3);
        req_valid = 1'b1; req_bank = 4'd1; req_idx = 2'd2;
        #1;
        chk("R8 data stalled", {31'b0, req_ready}, 0);
        req_valid = 1'b0;
        n = 0;
        @(negedge clk);
        while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
        chk("R7 held read data", rsp_rdata, tv ^ KEY);
        @(negedge clk);
        chk("R8 idle again", {31'b0, bus_req}, 0);

        summary();
        $finish;
    end

endmodule